// File: doc/BRIEF.md
# Shared-Memory Mailbox with Doorbell

This block passes messages between two processor ports through a small dual-port memory. The sending port writes the words of a message into the memory, one word per cycle. It then posts a doorbell that carries the start address and the word count of the message. The receiving port sees the doorbell raised, reads the words back through its own port, and then releases the mailbox. Because the message waits in memory, neither side has to stall on the other while the data moves.

Two mode inputs are sampled when the doorbell is posted. The first, `fixed_loc`, decides whether the message address comes with the post or is a location agreed in advance (the parameter `FIXED_BASE`). The second, `ack_mode`, decides how the mailbox is released. With `ack_mode` high, an explicit acknowledge pulse from the receiver clears the doorbell. With `ack_mode` low, the receiver's read of the final word clears it. While the doorbell is pending the sender sees a busy flag. A post during that time is refused and recorded in a sticky overflow flag.

Top module: `mbox_top`

## Requirements
- R1: After reset, `r_bell`, `s_busy`, `s_overflow` and `r_rdata` are 0, and so are `r_msg_addr` and `r_msg_len`.
- R2: A receiver read issued with `r_re` at address A in cycle t returns the last word written to A on `r_rdata` after the edge that ends cycle t. `r_rdata` holds its value while `r_re` is low.
- R3: A read and a write to the same address in the same cycle return the contents from before that write.
- R4: A post (`s_post`) while no doorbell is pending raises `r_bell`, `r_msg_addr` and `r_msg_len` one cycle later, never in the posting cycle. A word written in the posting cycle can be read from the first cycle in which `r_bell` is high. `s_post_len` must lie in 1..64.
- R5: If `fixed_loc` is 1 at the post, `r_msg_addr` becomes `FIXED_BASE` (default 32) and `s_post_addr` is ignored. If `fixed_loc` is 0, `r_msg_addr` takes `s_post_addr`.
- R6: If `ack_mode` was 1 at the post, an `r_ack` pulse while the doorbell is pending clears it on the next cycle. Receiver reads, including one of the final word, leave it set.
- R7: If `ack_mode` was 0 at the post, a receiver read at address (`r_msg_addr` + `r_msg_len` - 1) mod 64 clears the doorbell on the next cycle, and `r_ack` has no effect.
- R8: A post while the doorbell is pending leaves `r_bell`, `r_msg_addr` and `r_msg_len` unchanged. It sets `s_overflow` on the next cycle, and the flag stays set until reset.
- R9: `s_busy` equals `r_bell` in every cycle.
- R10: `r_ack` while no doorbell is pending changes neither `r_bell` nor `s_overflow`.
- R11: The final-word address wraps modulo 64, so a message that runs past address 63 is released by a read of its wrapped last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fixed_loc | input | 1 | 1: message lives at FIXED_BASE; sampled at post |
| ack_mode | input | 1 | 1: release by acknowledge; 0: release by final-word read; sampled at post |
| s_we | input | 1 | Sender word write enable |
| s_addr | input | 6 | Sender write address |
| s_wdata | input | 32 | Sender write data |
| s_post | input | 1 | Sender posts the doorbell |
| s_post_addr | input | 6 | Message start address carried with the post |
| s_post_len | input | 7 | Message length in words (1..64) |
| s_busy | output | 1 | Doorbell pending, mailbox not free |
| s_overflow | output | 1 | Sticky: a post was refused |
| r_re | input | 1 | Receiver read enable |
| r_addr | input | 6 | Receiver read address |
| r_rdata | output | 32 | Read data, one cycle after the read |
| r_ack | input | 1 | Receiver acknowledge pulse |
| r_bell | output | 1 | Message waiting |
| r_msg_addr | output | 6 | Start address of the waiting message |
| r_msg_len | output | 7 | Length of the waiting message |

## Verification
The assertions assume that every post carries a length between 1 and 64, and they check that assumption as a property on `s_post_len`. The ordering rules for refused posts and acknowledges hold for any input pattern. The stimulus draws each length from 1..8, or uses fixed lengths of up to 64 in directed cases, so it never breaks the length assumption. Before any read, it fills every memory word, so the read data is never undefined. Random traffic combines the two location modes and the two release modes. It adds idle gaps of random length and extra posts while the doorbell is pending, which exercises the refusal path. Directed cases cover address wrap, same-address read and write in one cycle, and an acknowledge with nothing pending.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MBOX_DW    = 32;
    localparam int MBOX_DEPTH = 64;

    // how a pending doorbell is released
    typedef enum logic {
        CLR_BY_ACK  = 1'b0,
        CLR_BY_READ = 1'b1
    } clr_src_e;
endpackage

// File: rtl/mbox_mem.sv
module mbox_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store_q [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    // write port: no reset on the storage array
    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    // read port: old contents win on a same-address collision
    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = store_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rd_data = rdata_q;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R2
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int FIXED_BASE = 32,
    localparam int AW        = $clog2(DEPTH),
    localparam int LW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fixed_loc,
    input  logic          ack_mode,
    input  logic          post,
    input  logic [AW-1:0] post_addr,
    input  logic [LW-1:0] post_len,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          ack,
    output logic          bell,
    output logic          overflow,
    output logic [AW-1:0] msg_addr,
    output logic [LW-1:0] msg_len
);
    typedef struct packed {
        logic          bell;
        logic          ovf;
        clr_src_e      clr;
        logic [AW-1:0] base;
        logic [LW-1:0] len;
    } bell_st_t;

    bell_st_t      st_d, st_q;
    logic [AW-1:0] last_addr;
    logic          release_hit;

    // final word of the pending message, wrapping inside the memory
    assign last_addr = st_q.base + st_q.len[AW-1:0] - AW'(1);

    always_comb begin
        st_d        = st_q;
        release_hit = 1'b0;
        if (st_q.bell) begin
            if (post) st_d.ovf = 1'b1;
            if (st_q.clr == CLR_BY_ACK) release_hit = ack;
            else                        release_hit = rd_en && (rd_addr == last_addr);
            if (release_hit) st_d.bell = 1'b0;
        end else if (post) begin
            st_d.bell = 1'b1;
            st_d.base = fixed_loc ? AW'(FIXED_BASE) : post_addr;
            st_d.len  = post_len;
            st_d.clr  = ack_mode ? CLR_BY_ACK : CLR_BY_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bell <= 1'b0;
            st_q.ovf  <= 1'b0;
            st_q.clr  <= CLR_BY_ACK;
            st_q.base <= '0;
            st_q.len  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bell     = st_q.bell;
    assign overflow = st_q.ovf;
    assign msg_addr = st_q.base;
    assign msg_len  = st_q.len;

    AST_POST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> (post_len != '0) && (int'(post_len) <= DEPTH)); // R4
    AST_BELL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (post && !bell) |=> bell); // R4
    AST_FIXED_LOCATION: assert property (@(posedge clk) disable iff (!rst_n)
        (post && !bell && fixed_loc) |=> (msg_addr == AW'(FIXED_BASE))); // R5
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bell && st_q.clr == CLR_BY_ACK && ack) |=> !bell); // R6
    AST_READ_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bell && st_q.clr == CLR_BY_READ && !rd_en) |=> bell); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bell && post) |=> ($stable(msg_addr) && $stable(msg_len) && overflow)); // R8
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bell && !post && ack) |=> (!bell && $stable(overflow))); // R10
endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DW         = MBOX_DW,
    parameter int DEPTH      = MBOX_DEPTH,
    parameter int FIXED_BASE = 32,
    localparam int AW        = $clog2(DEPTH),
    localparam int LW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fixed_loc,
    input  logic          ack_mode,
    input  logic          s_we,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    input  logic          s_post,
    input  logic [AW-1:0] s_post_addr,
    input  logic [LW-1:0] s_post_len,
    output logic          s_busy,
    output logic          s_overflow,
    input  logic          r_re,
    input  logic [AW-1:0] r_addr,
    output logic [DW-1:0] r_rdata,
    input  logic          r_ack,
    output logic          r_bell,
    output logic [AW-1:0] r_msg_addr,
    output logic [LW-1:0] r_msg_len
);
    logic bell_w;

    mbox_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s_we),
        .wr_addr (s_addr),
        .wr_data (s_wdata),
        .rd_en   (r_re),
        .rd_addr (r_addr),
        .rd_data (r_rdata)
    );

    mbox_doorbell #(.DEPTH(DEPTH), .FIXED_BASE(FIXED_BASE)) u_bell (
        .clk       (clk),
        .rst_n     (rst_n),
        .fixed_loc (fixed_loc),
        .ack_mode  (ack_mode),
        .post      (s_post),
        .post_addr (s_post_addr),
        .post_len  (s_post_len),
        .rd_en     (r_re),
        .rd_addr   (r_addr),
        .ack       (r_ack),
        .bell      (bell_w),
        .overflow  (s_overflow),
        .msg_addr  (r_msg_addr),
        .msg_len   (r_msg_len)
    );

    assign r_bell = bell_w;
    assign s_busy = bell_w;

    AST_BUSY_MIRRORS_BELL: assert property (@(posedge clk) disable iff (!rst_n)
        s_busy == r_bell); // R9
endmodule

// File: tb/sim_mbox_top.sv
module sim_mbox_top;
    localparam int DW = 32, DEPTH = 64, AW = 6, LW = 7, FIXB = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fixed_loc = 0, ack_mode = 0, s_we = 0, s_post = 0, r_re = 0, r_ack = 0;
    logic [AW-1:0] s_addr = '0, s_post_addr = '0, r_addr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic [LW-1:0] s_post_len = '0;
    logic s_busy, s_overflow, r_bell;
    logic [DW-1:0] r_rdata;
    logic [AW-1:0] r_msg_addr;
    logic [LW-1:0] r_msg_len;

    mbox_top u0 (.*);

    always #4 clk = ~clk; // 125 MHz

    int nvec = 0, nbad = 0;
    string tag = "R1";

    // reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_rdata = '0;
    logic m_bell = 0, m_ovf = 0, m_ackq = 0;
    logic [AW-1:0] m_base = '0;
    logic [LW-1:0] m_len = '0;

    function automatic logic [AW-1:0] final_word(input logic [AW-1:0] b, input logic [LW-1:0] l);
        return AW'(b + l[AW-1:0] - AW'(1));
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("bell", 32'(r_bell), 32'(m_bell));
        chk("busy", 32'(s_busy), 32'(m_bell));
        chk("overflow", 32'(s_overflow), 32'(m_ovf));
        chk("msg_addr", 32'(r_msg_addr), 32'(m_base));
        chk("msg_len", 32'(r_msg_len), 32'(m_len));
        chk("rdata", r_rdata, m_rdata);
    endtask

    task automatic model_edge();
        logic rel;
        if (r_re) m_rdata = m_mem[r_addr];
        if (m_bell) begin
            if (s_post) m_ovf = 1'b1;
            rel = m_ackq ? r_ack : (r_re && r_addr == final_word(m_base, m_len));
            if (rel) m_bell = 1'b0;
        end else if (s_post) begin
            m_bell = 1'b1;
            m_base = fixed_loc ? AW'(FIXB) : s_post_addr;
            m_len  = s_post_len;
            m_ackq = ack_mode;
        end
        if (s_we) m_mem[s_addr] = s_wdata;
    endtask

    // inputs already driven at a falling edge; advance one cycle and compare
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
        s_we = 0; s_post = 0; r_re = 0; r_ack = 0;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        s_we = 1; s_addr = AW'(a); s_wdata = d;
    endtask

    task automatic rd(input int a);
        r_re = 1; r_addr = AW'(a);
    endtask

    task automatic post(input int a, input int l, input logic fx, input logic am);
        s_post = 1; s_post_addr = AW'(a); s_post_len = LW'(l); fixed_loc = fx; ack_mode = am;
    endtask

    // write a message and post it together with its last word
    task automatic send(input int base, input int len, input logic fx, input logic am);
        int b;
        b = fx ? FIXB : base;
        for (int i = 0; i < len; i++) begin
            wr((b + i) % DEPTH, $urandom());
            if (i == len - 1) post(base, len, fx, am);
            step();
        end
    endtask

    task automatic receive_all();
        int b, l;
        b = int'(m_base); l = int'(m_len);
        for (int i = 0; i < l; i++) begin
            rd((b + i) % DEPTH);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        check_all();
        rst_n = 1;

        tag = "R2 fill";
        for (int i = 0; i < DEPTH; i++) begin wr(i, 32'hA500_0000 + 32'(i)); step(); end
        for (int i = 0; i < DEPTH; i += 7) begin rd(i); step(); end
        tag = "R2 hold";
        step(); step();

        tag = "R3 collision";
        wr(10, 32'hDEAD_BEEF); rd(10); step();
        rd(10); step();

        tag = "R10 idle ack";
        r_ack = 1; step();

        tag = "R4 post";
        wr(5, 32'h1); step(); wr(6, 32'h2); step();
        wr(7, 32'h3); post(5, 3, 0, 1); step();
        tag = "R6 reads keep";
        receive_all(); step();
        tag = "R8 refused";
        post(40, 2, 0, 0); step(); step();
        tag = "R6 ack";
        r_ack = 1; step(); step();

        tag = "R5 fixed";
        send(3, 4, 1, 1);
        receive_all(); r_ack = 1; step();

        tag = "R7 final read";
        send(20, 3, 0, 0);
        r_ack = 1; step();
        rd(21); step(); rd(22); step(); step();

        tag = "R11 wrap";
        send(62, 4, 0, 0);
        rd(63); step(); rd(1); step(); step();
        send(0, 64, 0, 0);
        rd(63); step();

        tag = "R9 random";
        for (int n = 0; n < 400; n++) begin
            logic fx, am;
            fx = 1'($urandom_range(0, 1)); am = 1'($urandom_range(0, 1));
            send($urandom_range(0, 63), $urandom_range(1, 8), fx, am);
            if ($urandom_range(0, 9) == 0) begin post($urandom_range(0, 63), 2, 0, 0); step(); end
            repeat ($urandom_range(0, 3)) step();
            receive_all();
            if (m_ackq) begin r_ack = 1; step(); end
            if ($urandom_range(0, 3) == 0) begin wr($urandom_range(0, 63), $urandom()); rd($urandom_range(0, 63)); step(); end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule